// File: doc/BRIEF.md
# Clear-on-read statistics memory port

This block holds a small memory of 32-bit bin counters that an accumulation engine updates during a frame. A bus master reads the counters back through a four-register window. It first writes a start index into the pointer register. It then reads the data register repeatedly. Each accepted read returns the counter under the pointer one cycle later and steps the pointer forward, wrapping from the last word back to word zero.

A control bit turns on clear-on-read. In that mode every entry that is read is also set to zero in the same access. One full sweep therefore hands back a frame's statistics and leaves the memory empty for the next frame. Software can also use a sweep whose data it discards purely to empty the memory. Once the bit is cleared, reads leave the contents untouched.

The memory has one write port. A read-clear therefore takes priority over an engine update in the same cycle. The update is parked for one cycle and `acc_hold` shows that it is waiting. While the engine reports itself busy, data reads are refused: the read data keeps its previous value and the pointer stays put. `busy` reports when the engine is active or an update is still parked.

Top module: `stat_readout`

## Requirements
- R1: After reset the pointer, the clear-mode bit, `bus_rdata`, `busy` and `acc_hold` are all zero, and every counter reads as zero.
- R2: Register decoding: index 0 is control (bit 0 = clear mode), 1 is the pointer, 2 is the data window and 3 is status (bit 0 = busy). A bus write to index 1 loads the pointer, and writing 0 selects the first word. A read of index 1 returns the pointer on `bus_rdata` one cycle later.
- R3: An accepted read of index 2 places the counter under the pointer on `bus_rdata` one cycle later and advances the pointer by one.
- R4: The pointer wraps from DEPTH-1 to 0.
- R5: With clear mode set, a read returns the entry's old value and leaves that entry at zero.
- R6: With clear mode off, reads do not change the memory, so repeated sweeps return the same values.
- R7: A pulse on `acc_valid` adds `acc_inc` to the counter at `acc_idx`, with 32-bit wraparound.
- R8: If a read-clear and an `acc_valid` pulse share a cycle, the clear is done and the update is parked. `acc_hold` is high in the next cycle, and the parked update is applied in that cycle, on top of the cleared value when the index matches. The engine must not pulse `acc_valid` while `acc_hold` is high.
- R9: While `eng_busy` is high, a data read is refused. `bus_rdata` keeps its prior value, the pointer does not move and no entry is cleared.
- R10: `busy` and status bit 0 are high exactly when `eng_busy` is high or an update is parked.
- R11: DEPTH data reads with clear mode on, starting from word 0, return every counter, leave the whole memory at zero and bring the pointer back to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| eng_busy | input | 1 | Accumulation engine active; data reads are refused while it is high |
| acc_valid | input | 1 | Counter update strobe |
| acc_idx | input | AW | Counter index to update |
| acc_inc | input | DW | Amount added to the counter |
| acc_hold | output | 1 | An update is parked and the engine must wait |
| busy | output | 1 | Engine active or update parked |

## Verification
Every register read has its result on `bus_rdata` one clock after the access is presented. The bench drives on the falling edge and samples on the next falling edge, so each read is checked against exactly one rising edge. After a collision, `acc_hold` is due one cycle later and clears the cycle after that. The bench checks both edges and only then issues the next access. Expected counter contents come from an arithmetic model in the bench that tracks every increment and every clearing read in the bench's own terms.

// File: rtl/stat_readout.sv
module stat_readout #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_busy,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_idx,
  input  logic [DW-1:0] acc_inc,
  output logic          acc_hold,
  output logic          busy
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [1:0] A_CTRL = 2'd0, A_PTR = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          clr_mode;
  logic          pend_v;
  logic [AW-1:0] pend_idx;
  logic [DW-1:0] pend_inc;

  logic          rd_any, rd_data, rd_ok, rd_clr, wr_any;
  logic          u_v;
  logic [AW-1:0] u_idx;
  logic [DW-1:0] u_inc;

  assign rd_any  = bus_sel && !bus_wr;
  assign wr_any  = bus_sel && bus_wr;
  assign rd_data = rd_any && bus_addr == A_DATA;
  assign rd_ok   = rd_data && !eng_busy;
  assign rd_clr  = rd_ok && clr_mode;

  assign u_v   = pend_v || acc_valid;
  assign u_idx = pend_v ? pend_idx : acc_idx;
  assign u_inc = pend_v ? pend_inc : acc_inc;

  assign acc_hold = pend_v;
  assign busy     = eng_busy || pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      pend_v   <= 1'b0;
      pend_idx <= '0;
      pend_inc <= '0;
    end else if (rd_clr) begin
      mem[ptr] <= '0;
      pend_v   <= u_v;
      pend_idx <= u_idx;
      pend_inc <= u_inc;
    end else begin
      pend_v <= 1'b0;
      if (u_v) mem[u_idx] <= mem[u_idx] + u_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      clr_mode <= 1'b0;
    end else if (wr_any && bus_addr == A_PTR) begin
      ptr <= bus_wdata[AW-1:0];
    end else if (wr_any && bus_addr == A_CTRL) begin
      clr_mode <= bus_wdata[0];
    end else if (rd_ok) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= DW'(clr_mode);
        A_PTR:   bus_rdata <= DW'(ptr);
        A_DATA:  if (!eng_busy) bus_rdata <= mem[ptr];
        default: bus_rdata <= DW'(busy);
      endcase
    end
  end

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && ptr == LAST |=> ptr == '0);

  a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && eng_busy |=> $stable(ptr) && $stable(bus_rdata));

  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && acc_valid |=> acc_hold);

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hold && !rd_clr |=> !acc_hold);

  a_r8_engine_waits: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hold |-> !acc_valid);

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> busy);
endmodule

// File: tb/sim_stat_readout.sv
module sim_stat_readout;
  localparam int D = 16;
  localparam int AWB = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic eng_busy = 0, acc_valid = 0;
  logic [AWB-1:0] acc_idx = 0;
  logic [31:0] acc_inc = 0;
  logic acc_hold, busy;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [D];
  logic [31:0] d;
  bit done = 0;

  always #5 clk = ~clk;

  stat_readout #(.DEPTH(D), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_inc(acc_inc), .acc_hold(acc_hold), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic acc(input int idx, input logic [31:0] inc);
    acc_valid = 1; acc_idx = AWB'(idx); acc_inc = inc;
    @(negedge clk);
    acc_valid = 0;
    model[idx] = model[idx] + inc;
  endtask

  task automatic collide(input int p, input int idx, input logic [31:0] inc);
    wr(2'd1, p);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'd2;
    acc_valid = 1; acc_idx = AWB'(idx); acc_inc = inc;
    @(negedge clk);
    bus_sel = 0; acc_valid = 0;
    chk("R8 clear returns old value", bus_rdata, model[p]);
    chk("R8 hold raised", {31'b0, acc_hold}, 32'd1);
    chk("R10 busy while parked", {31'b0, busy}, 32'd1);
    model[p] = 0;
    model[idx] = model[idx] + inc;
    @(negedge clk);
    chk("R8 hold released", {31'b0, acc_hold}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < D; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 hold", {31'b0, acc_hold}, 0);
    rd(2'd1, d); chk("R1 pointer", d, 0);
    rd(2'd0, d); chk("R1 clear bit", d, 0);
    for (int i = 0; i < D; i++) begin rd(2'd2, d); chk("R1 memory zero", d, 0); end
    // R7
    for (int i = 0; i < D; i++) acc(i, i * 7 + 3);
    for (int i = 0; i < D; i++) acc(i, 32'hFFFF_FFF0 + i);
    // R2
    wr(2'd1, 5); rd(2'd1, d); chk("R2 pointer load", d, 5);
    wr(2'd1, 0); rd(2'd1, d); chk("R2 pointer zero", d, 0);
    // R3, R7, R6
    for (int pass = 0; pass < 2; pass++)
      for (int i = 0; i < D; i++) begin
        rd(2'd2, d);
        chk(pass == 0 ? "R3 R7 sweep" : "R6 contents intact", d, model[i]);
      end
    rd(2'd1, d); chk("R4 pointer back at zero", d, 0);
    // R4
    wr(2'd1, D - 2);
    rd(2'd2, d); chk("R4 word D-2", d, model[D-2]);
    rd(2'd2, d); chk("R4 word D-1", d, model[D-1]);
    rd(2'd2, d); chk("R4 wrapped word 0", d, model[0]);
    // R9, R10
    wr(2'd1, 3);
    rd(2'd2, d); chk("R3 word 3", d, model[3]);
    eng_busy = 1;
    wr(2'd0, 1);
    rd(2'd2, d); chk("R9 rdata held", d, model[3]);
    rd(2'd2, d); chk("R9 rdata held again", d, model[3]);
    rd(2'd3, d); chk("R10 status busy", d, 1);
    chk("R10 busy pin", {31'b0, busy}, 1);
    eng_busy = 0;
    rd(2'd3, d); chk("R10 status idle", d, 0);
    rd(2'd1, d); chk("R9 pointer unmoved", d, 4);
    wr(2'd0, 0);
    rd(2'd2, d); chk("R9 entry not cleared", d, model[4]);
    // R8, R5
    wr(2'd0, 1);
    collide(6, 6, 9);
    collide(7, 2, 5);
    wr(2'd0, 0);
    wr(2'd1, 6); rd(2'd2, d); chk("R8 update after clear", d, 9);
    rd(2'd2, d); chk("R5 entry zeroed", d, 0);
    wr(2'd1, 2); rd(2'd2, d); chk("R8 parked update other index", d, model[2]);
    // R11
    wr(2'd0, 1); wr(2'd1, 0);
    for (int i = 0; i < D; i++) begin
      rd(2'd2, d); chk("R5 clearing read value", d, model[i]); model[i] = 0;
    end
    rd(2'd1, d); chk("R11 pointer home", d, 0);
    wr(2'd0, 0);
    for (int i = 0; i < D; i++) begin rd(2'd2, d); chk("R11 memory empty", d, 0); end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule